// File: doc/BRIEF.md
# Maskable Time-of-Day Alarm Matcher

This block holds two alarm settings and tests them against the current calendar time. It does this only on the once-per-second update strobe. The first alarm, alarm A, looks at seconds, minutes, hours and a day-or-date field. The second alarm, alarm B, looks at minutes, hours and a day-or-date field, and it can only fire when the seconds value is 00.

Each alarm byte has a mask bit in its most significant bit. A set mask bit takes that field out of the comparison, and this is how the repeat rate is chosen. In the day-or-date byte, bit 6 selects whether the low six bits are compared with the day of week or with the date of the month.

A match sets a sticky flag for its alarm. A host clears the flag only by writing 0 to its bit. A single active-low pin serves two uses:
- When the interrupt-select bit is 1, the pin is an interrupt line, driven low while any enabled flag is set.
- When the interrupt-select bit is 0, the pin passes an external square wave.

The timekeeping counter, the square-wave generator and the bus interface are separate blocks.

Top module: `alarm_match`

## Requirements
- R1: After reset, both flags are 0 and `irq_sq_n` is 1. The interrupt-select bit resets to 1, and both alarm enables reset to 0.
- R2: The register write map is as follows. Any other address is ignored.
  - Addresses 0, 1, 2 and 3 hold alarm A seconds, minutes, hours and day/date.
  - Addresses 4, 5 and 6 hold alarm B minutes, hours and day/date.
  - Address 7 is control: bit 2 is interrupt-select, bit 1 enables B, bit 0 enables A.
  - Address 8 is the flag register: bit 1 is flag B, bit 0 is flag A.
  - With every mask bit 0, alarm A sets its flag only when all four of its fields equal the current time.
- R3: Bit 7 of each alarm byte is a mask, and a set mask removes that field from the comparison. For alarm A, the mask patterns (day/date, hours, minutes, seconds) give the following rates:
  - 1111 fires every second.
  - 1110 fires when seconds match.
  - 1100 fires when minutes and seconds match.
  - 1000 fires when hours, minutes and seconds match.
- R4: Alarm B only matches when the current seconds value is 00. With all three of its masks set, it fires once per minute.
- R5: In a day/date alarm byte, bit 6 = 1 compares bits 5:0 with `cur_day`, and bit 6 = 0 compares them with `cur_date`.
- R6: Comparisons take place only in a cycle where `tick` is 1. The flag is set at the next clock edge.
- R7: A match sets its flag whatever the interrupt-select bit and the enables hold.
- R8: Writing 0 to a flag bit at address 8 clears that flag. Writing 1 leaves it unchanged.
- R9: When interrupt-select is 1, `irq_sq_n` is 0 exactly while some flag is set together with its enable.
- R10: When interrupt-select is 0, `irq_sq_n` follows `sq_in`, whatever the flags hold.
- R11: The hours comparison covers the stored bits 6:0 bit for bit, including the 12/24 mode bit and the AM/PM bit.
- R12: If a clearing write and a new match fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Once-per-second update strobe; time inputs hold the new time in this cycle |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours byte (mode, AM/PM, BCD) |
| cur_day | input | 8 | Current day of week |
| cur_date | input | 8 | Current date of month, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| sq_in | input | 1 | Square wave to pass through |
| flag_a | output | 1 | Alarm A sticky flag |
| flag_b | output | 1 | Alarm B sticky flag |
| irq_sq_n | output | 1 | Active-low interrupt or square-wave output |

## Verification
A corrupted alarm byte, mask or selector shows up at the flag outputs one cycle after the first tick whose time it misjudges. The flag either sets when it should not, or fails to set. A wrong control bit shows up at `irq_sq_n` in the same cycle as the write's edge, because the pin is a purely combinational function of flags, enables and the select bit. A flag that is lost or stuck stays visible indefinitely, because only a host write changes it.

// File: rtl/alarm_match.sv
module alarm_match #(
  parameter logic [3:0] CTRL_ADDR = 4'd7,
  parameter logic [3:0] FLAG_ADDR = 4'd8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] cur_sec,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_hour,
  input  logic [7:0] cur_day,
  input  logic [7:0] cur_date,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       sq_in,
  output logic       flag_a,
  output logic       flag_b,
  output logic       irq_sq_n
);

  logic [7:0] a_sec, a_min, a_hr, a_dd;
  logic [7:0] b_min, b_hr, b_dd;
  logic       int_sel, en_a, en_b;
  logic       match_a, match_b;
  logic       clr_a, clr_b;

  function automatic logic fld_ok(input logic [7:0] r, input logic [7:0] c);
    return r[7] | (r[6:0] == c[6:0]);
  endfunction

  function automatic logic dd_ok(input logic [7:0] r, input logic [7:0] day,
                                 input logic [7:0] date);
    return r[7] | (r[6] ? (r[5:0] == day[5:0]) : (r[5:0] == date[5:0]));
  endfunction

  assign match_a = tick & fld_ok(a_sec, cur_sec) & fld_ok(a_min, cur_min)
                 & fld_ok(a_hr, cur_hour) & dd_ok(a_dd, cur_day, cur_date);

  assign match_b = tick & (cur_sec == 8'h00) & fld_ok(b_min, cur_min)
                 & fld_ok(b_hr, cur_hour) & dd_ok(b_dd, cur_day, cur_date);

  assign clr_a = wr_en && wr_addr == FLAG_ADDR && !wr_data[0];
  assign clr_b = wr_en && wr_addr == FLAG_ADDR && !wr_data[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_sec   <= '0;
      a_min   <= '0;
      a_hr    <= '0;
      a_dd    <= '0;
      b_min   <= '0;
      b_hr    <= '0;
      b_dd    <= '0;
      int_sel <= 1'b1;
      en_a    <= 1'b0;
      en_b    <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        4'd0: a_sec <= wr_data;
        4'd1: a_min <= wr_data;
        4'd2: a_hr  <= wr_data;
        4'd3: a_dd  <= wr_data;
        4'd4: b_min <= wr_data;
        4'd5: b_hr  <= wr_data;
        4'd6: b_dd  <= wr_data;
        CTRL_ADDR: begin
          int_sel <= wr_data[2];
          en_b    <= wr_data[1];
          en_a    <= wr_data[0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_a <= 1'b0;
      flag_b <= 1'b0;
    end else begin
      flag_a <= match_a | (flag_a & ~clr_a);
      flag_b <= match_b | (flag_b & ~clr_b);
    end
  end

  assign irq_sq_n = int_sel ? ~((flag_a & en_a) | (flag_b & en_b)) : sq_in;

  // R6
  flag_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_a) || $rose(flag_b)) |-> $past(tick));

  // R4
  b_at_zero_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_b) |-> $past(cur_sec) == 8'h00);

  // R8
  clear_by_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_a) |-> $past(wr_en && wr_addr == FLAG_ADDR && !wr_data[0]));

  // R12
  match_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_a || match_b) |=> (flag_a || flag_b));

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_sel && !irq_sq_n) |-> (flag_a || flag_b));

endmodule

// File: tb/alarm_match_tb.sv
module alarm_match_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [7:0] cur_sec = 0, cur_min = 0, cur_hour = 0, cur_day = 0, cur_date = 0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic sq_in = 1'b0;
  logic flag_a, flag_b, irq_sq_n;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alarm_match u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_day(cur_day), .cur_date(cur_date),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sq_in(sq_in), .flag_a(flag_a), .flag_b(flag_b), .irq_sq_n(irq_sq_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, m, h, dy, dt);
    cur_sec = s; cur_min = m; cur_hour = h; cur_day = dy; cur_date = dt;
  endtask

  task automatic pulse(input logic [7:0] s, m, h, dy, dt);
    @(negedge clk);
    set_time(s, m, h, dy, dt);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_a(input logic [7:0] s, m, h, dd);
    wr(4'd0, s); wr(4'd1, m); wr(4'd2, h); wr(4'd3, dd);
  endtask

  task automatic set_b(input logic [7:0] m, h, dd);
    wr(4'd4, m); wr(4'd5, h); wr(4'd6, dd);
  endtask

  task automatic clear_all();
    wr(4'd8, 8'h00);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 flags", {6'd0, flag_b, flag_a}, 8'h00);
    check("R1 pin", {7'd0, irq_sq_n}, 8'h01);
  endtask

  task automatic t_full();
    set_a(8'h30, 8'h15, 8'h08, 8'h12);
    pulse(8'h30, 8'h15, 8'h08, 8'h02, 8'h13);
    check("R2 date differs", {7'd0, flag_a}, 8'h00);
    pulse(8'h30, 8'h16, 8'h08, 8'h02, 8'h12);
    check("R2 minute differs", {7'd0, flag_a}, 8'h00);
    pulse(8'h30, 8'h15, 8'h08, 8'h02, 8'h12);
    check("R2 full match", {7'd0, flag_a}, 8'h01);
    clear_all();
  endtask

  task automatic t_masks();
    set_a(8'h80, 8'h80, 8'h80, 8'h80);
    pulse(8'h07, 8'h33, 8'h11, 8'h05, 8'h21);
    check("R3 every second", {7'd0, flag_a}, 8'h01);
    clear_all();
    set_a(8'h45, 8'h80, 8'h80, 8'h80);
    pulse(8'h44, 8'h10, 8'h10, 8'h01, 8'h01);
    check("R3 seconds mismatch", {7'd0, flag_a}, 8'h00);
    pulse(8'h45, 8'h59, 8'h23, 8'h07, 8'h31);
    check("R3 seconds match", {7'd0, flag_a}, 8'h01);
    clear_all();
    set_a(8'h45, 8'h20, 8'h80, 8'h80);
    pulse(8'h45, 8'h21, 8'h05, 8'h01, 8'h01);
    check("R3 min+sec mismatch", {7'd0, flag_a}, 8'h00);
    pulse(8'h45, 8'h20, 8'h17, 8'h04, 8'h09);
    check("R3 min+sec match", {7'd0, flag_a}, 8'h01);
    clear_all();
    set_a(8'h45, 8'h20, 8'h17, 8'h80);
    pulse(8'h45, 8'h20, 8'h16, 8'h04, 8'h09);
    check("R3 h+m+s mismatch", {7'd0, flag_a}, 8'h00);
    pulse(8'h45, 8'h20, 8'h17, 8'h06, 8'h28);
    check("R3 h+m+s match", {7'd0, flag_a}, 8'h01);
    clear_all();
  endtask

  task automatic t_minute();
    set_b(8'h80, 8'h80, 8'h80);
    pulse(8'h01, 8'h10, 8'h10, 8'h01, 8'h01);
    check("R4 sec 01 no fire", {7'd0, flag_b}, 8'h00);
    pulse(8'h00, 8'h11, 8'h10, 8'h01, 8'h01);
    check("R4 sec 00 fire", {7'd0, flag_b}, 8'h01);
    clear_all();
  endtask

  task automatic t_daydate();
    set_a(8'h00, 8'h00, 8'h00, 8'h43);
    pulse(8'h00, 8'h00, 8'h00, 8'h03, 8'h05);
    check("R5 day select", {7'd0, flag_a}, 8'h01);
    clear_all();
    wr(4'd3, 8'h03);
    pulse(8'h00, 8'h00, 8'h00, 8'h03, 8'h05);
    check("R5 date select mismatch", {7'd0, flag_a}, 8'h00);
    pulse(8'h00, 8'h00, 8'h00, 8'h06, 8'h03);
    check("R5 date select match", {7'd0, flag_a}, 8'h01);
    clear_all();
  endtask

  task automatic t_tick_only();
    set_a(8'h80, 8'h80, 8'h80, 8'h80);
    @(negedge clk);
    set_time(8'h01, 8'h02, 8'h03, 8'h04, 8'h05);
    repeat (5) @(negedge clk);
    check("R6 no tick no flag", {7'd0, flag_a}, 8'h00);
    @(negedge clk) tick = 1'b1;
    check("R6 not before edge", {7'd0, flag_a}, 8'h00);
    @(negedge clk) tick = 1'b0;
    check("R6 set after edge", {7'd0, flag_a}, 8'h01);
    clear_all();
  endtask

  task automatic t_indep();
    wr(4'd7, 8'h00);
    pulse(8'h00, 8'h00, 8'h00, 8'h01, 8'h01);
    check("R7 flags set with int off", {6'd0, flag_b, flag_a}, 8'h03);
    wr(4'd7, 8'h04);
    check("R7 flags set, enables off, pin high", {7'd0, irq_sq_n}, 8'h01);
  endtask

  task automatic t_clear();
    wr(4'd8, 8'h03);
    check("R8 write ones keeps", {6'd0, flag_b, flag_a}, 8'h03);
    wr(4'd8, 8'h02);
    check("R8 clear A only", {6'd0, flag_b, flag_a}, 8'h02);
    wr(4'd5, 8'h00);
    check("R2 other address keeps flags", {6'd0, flag_b, flag_a}, 8'h02);
    wr(4'd8, 8'h00);
    check("R8 clear B", {6'd0, flag_b, flag_a}, 8'h00);
  endtask

  task automatic t_pin();
    set_b(8'h05, 8'h80, 8'h80);
    pulse(8'h00, 8'h00, 8'h00, 8'h01, 8'h01);
    check("R9 only A set", {6'd0, flag_b, flag_a}, 8'h01);
    wr(4'd7, 8'h05);
    check("R9 A enabled pin low", {7'd0, irq_sq_n}, 8'h00);
    wr(4'd7, 8'h06);
    check("R9 only B enabled pin high", {7'd0, irq_sq_n}, 8'h01);
    wr(4'd7, 8'h00);
    @(negedge clk) sq_in = 1'b1;
    #1 check("R10 follows sq high", {7'd0, irq_sq_n}, 8'h01);
    @(negedge clk) sq_in = 1'b0;
    #1 check("R10 follows sq low", {7'd0, irq_sq_n}, 8'h00);
    wr(4'd7, 8'h03);
    @(negedge clk) sq_in = 1'b1;
    #1 check("R10 enables ignored", {7'd0, irq_sq_n}, 8'h01);
    wr(4'd7, 8'h04);
    clear_all();
  endtask

  task automatic t_hour();
    set_a(8'h80, 8'h80, 8'h48, 8'h80);
    pulse(8'h00, 8'h00, 8'h08, 8'h01, 8'h01);
    check("R11 mode bit differs", {7'd0, flag_a}, 8'h00);
    pulse(8'h00, 8'h00, 8'h68, 8'h01, 8'h01);
    check("R11 AM/PM differs", {7'd0, flag_a}, 8'h00);
    pulse(8'h00, 8'h00, 8'h48, 8'h01, 8'h01);
    check("R11 exact hour", {7'd0, flag_a}, 8'h01);
  endtask

  task automatic t_race();
    @(negedge clk);
    set_time(8'h00, 8'h00, 8'h48, 8'h01, 8'h01);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 4'd8; wr_data = 8'h00;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    check("R12 match beats clear", {7'd0, flag_a}, 8'h01);
    clear_all();
    check("R12 later clear works", {7'd0, flag_a}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full();
    t_masks();
    t_minute();
    t_daydate();
    t_tick_only();
    t_indep();
    t_clear();
    t_pin();
    t_hour();
    t_race();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule